// File: doc/BRIEF.md
# Low-Power Domain Register Write Synchronizer

This block is the bus-side register front end of a peripheral whose storage sits in a slow, separately clocked low-power (LP) domain. The LP domain holds the time seconds, the time fraction, the alarm seconds, the alarm fraction and the control register. A bus write to any of these, or to the status register, is latched into a holding stage. The holding stage is then handed to the LP domain by a toggle handshake. Each direction of that handshake passes through a two-flop synchronizer. When the LP domain acknowledges, the front end reports completion through its status flags. The interrupt-enable register does not cross domains. It lives entirely on the bus clock and updates at bus speed.

Only one synchronized write can be in flight at a time. Software polls the busy flag, or enables the write-complete interrupt, before it issues the next write. A write that arrives too early is dropped and recorded as a write error. Alarm and security-violation events enter from the LP side. A non-valid flag is raised by LP reset. Each of these is cleared by a synchronized write of a one to its status bit. The register interface is a plain single-cycle bus with no back-pressure. Software flow control is the busy flag. The single interrupt line is the OR of every enabled flag.

Top module: `lpd_write_sync`

## Requirements
- R1: Within four bus cycles of reset release, the status register (byte address 0x14) reads 0x0000_0202: write-next (bit 9) and non-valid (bit 1) set, all else zero. The interrupt-enable register (0x18) reads zero and `irq` is low.
- R2: Writes to byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 are synchronized writes. In the cycle after one is accepted, status bit 10 (write busy) reads 1 and bit 9 (write next) reads 0. Both hold until the LP domain acknowledges. Write next is always the inverse of write busy.
- R3: When a synchronized write completes, write busy clears and status bit 8 (write complete) sets in the same cycle. From then on, a read of the written data register (0x00–0x10) returns the full 32-bit value written.
- R4: A status read returns the flags as they stood before the read edge and clears write complete. If a completion lands on the same edge, write complete stays set.
- R5: A write to 0x18 stores `bus_wdata` masked to bits 9, 8, 7 and 4 on the next edge. It never sets write busy or write complete.
- R6: A synchronized write issued while write busy is set is discarded, so the target keeps its earlier value. It also sets status bit 7 (write error).
- R7: A write to 0x14 with a one in bit 7, 4, 1 or 0 clears that flag (write error, alarm, non-valid, security violation). The clear takes effect when the write completes. Bits written as zero leave their flags unchanged. The clearing write itself sets write complete.
- R8: A one-LP-cycle pulse on `lp_alarm_evt` sets status bit 4, and one on `lp_tamper_evt` sets status bit 0. Each bit reads as set on the bus within 8 bus cycles.
- R9: `irq` is high exactly when, for any of bits 9, 8, 7, 4, the status bit and the same interrupt-enable bit are both one.
- R10: `bus_rdata` is registered: it shows the addressed value on the edge where `bus_rd` is sampled and holds it until the next read. Byte address 0x1C reads zero, and writes to it are ignored and start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain active-low reset |
| lp_clk | input | 1 | Low-power domain clock |
| lp_rst_n | input | 1 | LP-domain active-low reset |
| bus_addr | input | 5 | Byte address; bits 1:0 ignored |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, OR of enabled flags |
| lp_alarm_evt | input | 1 | Alarm-match pulse from the LP counter (LP clock) |
| lp_tamper_evt | input | 1 | Security-violation pulse (LP clock) |

## Verification
Interrupt-enable writes and `irq` are due one bus cycle after the write edge. Read data is due one cycle after the read strobe. Write busy is due one cycle after the write is accepted. The bench drives on the falling edge and samples at the next falling edge, which lands exactly on those cycles. Completion of a synchronized write crosses two synchronizers, so its cycle count depends on the LP clock ratio. The bench therefore polls the status register until write busy drops and checks the flags carried by that read, which is the first read after completion. LP-side events get a fixed 8-cycle allowance before they are sampled.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
  localparam int AW = 5;

  typedef enum logic [2:0] {
    IX_SEC   = 3'd0,
    IX_FRAC  = 3'd1,
    IX_ASEC  = 3'd2,
    IX_AFRAC = 3'd3,
    IX_CTRL  = 3'd4,
    IX_STAT  = 3'd5,
    IX_IEN   = 3'd6,
    IX_NONE  = 3'd7
  } reg_ix_e;

  // status / enable bit positions (enable uses the same positions)
  localparam int B_BUSY  = 10;
  localparam int B_NEXT  = 9;
  localparam int B_DONE  = 8;
  localparam int B_WERR  = 7;
  localparam int B_ALARM = 4;
  localparam int B_NVAL  = 1;
  localparam int B_SVIO  = 0;

  // LP flag vector order
  localparam int F_ALARM = 2;
  localparam int F_NVAL  = 1;
  localparam int F_SVIO  = 0;
  localparam int NFLAG   = 3;
endpackage

// File: rtl/ldw_sync.sv
module ldw_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ldw_lp_stub.sv
module ldw_lp_stub
  import ldw_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 5
) (
  input  logic                     lp_clk,
  input  logic                     lp_rst_n,
  input  logic                     req_s,
  input  logic [2:0]               hold_ix,
  input  logic [DW-1:0]            hold_data,
  input  logic                     alarm_evt,
  input  logic                     tamper_evt,
  output logic                     ack_tgl,
  output logic [NREG-1:0][DW-1:0]  regs,
  output logic [NFLAG-1:0]         flags
);
  logic req_q;
  logic go;

  assign go = req_s ^ req_q;

  always_ff @(posedge lp_clk or negedge lp_rst_n) begin
    if (!lp_rst_n) begin
      req_q   <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      req_q <= req_s;
      if (go) ack_tgl <= ~ack_tgl;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] val_q;
      always_ff @(posedge lp_clk or negedge lp_rst_n) begin
        if (!lp_rst_n)                        val_q <= '0;
        else if (go && hold_ix == 3'(g))      val_q <= hold_data;
      end
      assign regs[g] = val_q;
    end
  endgenerate

  // non-valid comes up set after an LP reset
  always_ff @(posedge lp_clk or negedge lp_rst_n) begin
    if (!lp_rst_n) begin
      flags <= NFLAG'(1 << F_NVAL);
    end else begin
      if (go && hold_ix == 3'(IX_STAT))
        flags <= flags & ~{hold_data[B_ALARM], hold_data[B_NVAL], hold_data[B_SVIO]};
      if (alarm_evt)  flags[F_ALARM] <= 1'b1;
      if (tamper_evt) flags[F_SVIO]  <= 1'b1;
    end
  end
endmodule

// File: rtl/ldw_bus_ctl.sv
module ldw_bus_ctl
  import ldw_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic                     irq,
  input  logic                     ack_s,
  input  logic [NFLAG-1:0]         lp_flags_s,
  input  logic [NREG-1:0][DW-1:0]  lp_regs,
  output logic                     req_tgl,
  output logic [2:0]               hold_ix,
  output logic [DW-1:0]            hold_data,
  output logic                     busy,
  output logic                     wcf,
  output logic                     wef,
  output logic                     done,
  output logic [DW-1:0]            ier
);
  localparam logic [DW-1:0] IEN_MASK =
    DW'((1 << B_NEXT) | (1 << B_DONE) | (1 << B_WERR) | (1 << B_ALARM));

  reg_ix_e       ix;
  logic          ack_q;
  logic          sync_wr;
  logic          ien_wr;
  logic          rd_stat;
  logic [DW-1:0] stat_word;
  logic [DW-1:0] rd_mux;

  assign ix      = reg_ix_e'(bus_addr[4:2]);
  assign sync_wr = bus_wr && (ix <= IX_STAT);
  assign ien_wr  = bus_wr && (ix == IX_IEN);
  assign rd_stat = bus_rd && (ix == IX_STAT);
  assign done    = ack_s ^ ack_q;

  always_comb begin
    stat_word          = '0;
    stat_word[B_BUSY]  = busy;
    stat_word[B_NEXT]  = ~busy;
    stat_word[B_DONE]  = wcf;
    stat_word[B_WERR]  = wef;
    stat_word[B_ALARM] = lp_flags_s[F_ALARM];
    stat_word[B_NVAL]  = lp_flags_s[F_NVAL];
    stat_word[B_SVIO]  = lp_flags_s[F_SVIO];
  end

  always_comb begin
    case (ix)
      IX_STAT: rd_mux = stat_word;
      IX_IEN:  rd_mux = ier;
      IX_NONE: rd_mux = '0;
      default: rd_mux = lp_regs[ix];
    endcase
  end

  assign irq = |(stat_word & ier);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q     <= 1'b0;
      busy      <= 1'b0;
      wcf       <= 1'b0;
      wef       <= 1'b0;
      req_tgl   <= 1'b0;
      hold_ix   <= 3'(IX_NONE);
      hold_data <= '0;
      ier       <= '0;
      bus_rdata <= '0;
    end else begin
      ack_q <= ack_s;
      if (rd_stat) wcf <= 1'b0;
      if (done) begin
        busy <= 1'b0;
        wcf  <= 1'b1;
        if (hold_ix == 3'(IX_STAT) && hold_data[B_WERR]) wef <= 1'b0;
      end
      if (sync_wr) begin
        if (busy) begin
          wef <= 1'b1;
        end else begin
          busy      <= 1'b1;
          req_tgl   <= ~req_tgl;
          hold_ix   <= ix;
          hold_data <= bus_wdata;
        end
      end
      if (ien_wr) ier <= bus_wdata & IEN_MASK;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/lpd_write_sync.sv
module lpd_write_sync
  import ldw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_clk,
  input  logic          lp_rst_n,
  input  logic [4:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  input  logic          lp_alarm_evt,
  input  logic          lp_tamper_evt
);
  localparam int NREG = 5;

  logic                    req_tgl, req_s, ack_tgl, ack_s;
  logic [2:0]              hold_ix;
  logic [DW-1:0]           hold_data;
  logic [NREG-1:0][DW-1:0] lp_regs;
  logic [NFLAG-1:0]        lp_flags, lp_flags_s;
  logic                    busy, wcf, wef, done;
  logic [DW-1:0]           ier;

  ldw_sync #(.W(1)) u_req_sync (
    .clk(lp_clk), .rst_n(lp_rst_n), .d(req_tgl), .q(req_s)
  );

  ldw_sync #(.W(NFLAG + 1)) u_back_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ack_tgl, lp_flags}), .q({ack_s, lp_flags_s})
  );

  ldw_bus_ctl #(.DW(DW), .NREG(NREG)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ack_s(ack_s), .lp_flags_s(lp_flags_s), .lp_regs(lp_regs),
    .req_tgl(req_tgl), .hold_ix(hold_ix), .hold_data(hold_data),
    .busy(busy), .wcf(wcf), .wef(wef), .done(done), .ier(ier)
  );

  ldw_lp_stub #(.DW(DW), .NREG(NREG)) u_lp (
    .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
    .req_s(req_s), .hold_ix(hold_ix), .hold_data(hold_data),
    .alarm_evt(lp_alarm_evt), .tamper_evt(lp_tamper_evt),
    .ack_tgl(ack_tgl), .regs(lp_regs), .flags(lp_flags)
  );
endmodule

// File: rtl/ldw_chk.sv
module ldw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        busy,
  input logic        wcf,
  input logic        wef,
  input logic        done,
  input logic [31:0] ier
);
  logic [2:0] a_ix;
  assign a_ix = bus_addr[4:2];

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a_ix <= 3'd5 && !busy) |=> busy); // R2
  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a_ix <= 3'd5 && busy) |=> wef); // R6
  AST_DONE_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcf) |-> $past(done)); // R3
  AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && a_ix == 3'd5 && !done) |=> !wcf); // R4
  AST_IEN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a_ix == 3'd6 && !busy && !bus_rd) |=> (!busy && $stable(wcf))); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 32'd0) |-> !irq); // R9
  AST_IEN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && a_ix == 3'd6 && !bus_wr) |=> (bus_rdata == $past(ier))); // R10
endmodule

bind lpd_write_sync ldw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq), .busy(busy),
  .wcf(wcf), .wef(wef), .done(done), .ier(ier)
);

// File: tb/lpd_write_sync_tb.sv
module lpd_write_sync_tb;
  localparam logic [4:0] A_SEC = 5'h00, A_FRAC = 5'h04, A_ASEC = 5'h08,
                         A_AFRAC = 5'h0C, A_CTRL = 5'h10, A_STAT = 5'h14,
                         A_IEN = 5'h18, A_HOLE = 5'h1C;

  logic        clk = 0, lp_clk = 0, rst_n = 0, lp_rst_n = 0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        lp_alarm_evt = 0, lp_tamper_evt = 0;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] model [5];

  always #5  clk = ~clk;
  always #15 lp_clk = ~lp_clk;

  lpd_write_sync u_dut (
    .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .lp_alarm_evt(lp_alarm_evt), .lp_tamper_evt(lp_tamper_evt)
  );

  function automatic logic exp_irq(logic [31:0] en, logic [31:0] st);
    return |(en & st & 32'h0000_0390);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h400;
    for (int i = 0; i < 200; i++) begin
      rd(A_STAT, st);
      if (!st[10]) return;
    end
    chk("R3 completion timeout", st, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, st;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1; lp_rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); chk("R1 status", v, 32'h0000_0202);
    rd(A_IEN, v);  chk("R1 ien", v, 32'd0);

    // R2 / R3 / R4 basic synchronized write
    wr(A_SEC, 32'h1234_5678);
    rd(A_STAT, v); chk("R2 busy/next while in flight", v & 32'h600, 32'h400);
    wait_idle(st); chk("R3 complete flag", st & 32'h100, 32'h100);
    chk("R2 next after completion", st & 32'h600, 32'h200);
    rd(A_SEC, v);  chk("R3 readback", v, 32'h1234_5678);
    rd(A_STAT, v); chk("R4 complete cleared by read", v & 32'h100, 32'h0);

    // R6 collision
    wr(A_AFRAC, 32'h0000_A5A5);
    wr(A_AFRAC, 32'h0000_FFFF);
    wait_idle(st); chk("R6 write error set", st & 32'h80, 32'h80);
    rd(A_AFRAC, v); chk("R6 dropped write", v, 32'h0000_A5A5);
    wr(A_IEN, 32'h80); chk("R9 irq on write error", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h80);
    wait_idle(st); chk("R7 write error cleared", st & 32'h80, 32'h0);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);

    // R5 enable register bypass
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R5 no busy/complete", v & 32'h500, 32'h0);
    rd(A_IEN, v);  chk("R5 mask", v, 32'h0000_0390);
    chk("R9 irq from write-next", {31'd0, irq}, 32'd1);
    wr(A_IEN, 32'h0);

    // R8 LP events
    @(negedge lp_clk); lp_alarm_evt = 1; @(negedge lp_clk); lp_alarm_evt = 0;
    repeat (8) @(negedge clk);
    rd(A_STAT, v); chk("R8 alarm flag", v & 32'h10, 32'h10);
    @(negedge lp_clk); lp_tamper_evt = 1; @(negedge lp_clk); lp_tamper_evt = 0;
    repeat (8) @(negedge clk);
    rd(A_STAT, v); chk("R8 tamper flag", v & 32'h13, 32'h13);
    wr(A_IEN, 32'h10); chk("R9 irq on alarm", {31'd0, irq}, 32'd1);

    // R7 selective clears
    wr(A_STAT, 32'h02);
    wait_idle(st); chk("R7 only non-valid cleared", st & 32'h13, 32'h11);
    wr(A_STAT, 32'h11);
    wait_idle(st); chk("R7 alarm+tamper cleared", st & 32'h93, 32'h0);
    chk("R7 clear write completes", st & 32'h100, 32'h100);
    chk("R9 irq after alarm clear", {31'd0, irq}, 32'd0);

    // R4 / R9 write-complete interrupt
    wr(A_IEN, 32'h100);
    wr(A_CTRL, 32'h8);
    repeat (60) @(negedge clk);
    chk("R9 irq on write complete", {31'd0, irq}, 32'd1);
    rd(A_STAT, v);
    chk("R4 read saw complete", v & 32'h100, 32'h100);
    chk("R4 irq drops after read", {31'd0, irq}, 32'd0);
    rd(A_CTRL, v); chk("R3 ctrl readback", v, 32'h8);
    wr(A_IEN, 32'h0);

    // R10 hole address
    rd(A_HOLE, v); chk("R10 hole reads zero", v, 32'h0);
    wr(A_HOLE, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R10 hole write no transfer", v & 32'h400, 32'h0);
    rd(A_HOLE, v); chk("R10 hole still zero", v, 32'h0);

    // constrained random writes with occasional collisions
    model[0] = 32'h1234_5678; model[1] = 0; model[2] = 0;
    model[3] = 32'h0000_A5A5; model[4] = 32'h8;
    for (int it = 0; it < 24; it++) begin
      int idx, j;
      logic [31:0] d, en;
      bit coll;
      idx = int'($urandom % 5);
      d = $urandom;
      coll = ($urandom % 4) == 0;
      wr(5'(idx * 4), d);
      if (coll) wr(5'(((idx + 1) % 5) * 4), ~d);
      wait_idle(st);
      model[idx] = d;
      chk("R3 random complete", st & 32'h100, 32'h100);
      chk("R6 random error flag", st & 32'h80, coll ? 32'h80 : 32'h0);
      if (coll) begin
        wr(A_STAT, 32'h80);
        wait_idle(st);
      end
      j = int'($urandom % 5);
      rd(5'(j * 4), v); chk("R3 random readback", v, model[j]);
      en = $urandom & 32'h390;
      wr(A_IEN, en);
      chk("R9 random irq", {31'd0, irq}, {31'd0, exp_irq(en, 32'h200)});
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule